// File: doc/BRIEF.md
# Interlaced Cursor Row Sequencer

This block chooses which row of a 64-row cursor pattern belongs on each scan line of the display. It sits between the display timing logic and the cursor pattern store. A start-of-field pulse arms it for the field about to be drawn. On every scan-line strobe it answers with a row address and a flag that says whether the cursor covers that line at all.

The vertical position register holds the screen line just below the cursor's bottom row, offset by 64. A value of 64 therefore puts pattern row 0 on screen line 0, and smaller values push the cursor above the top edge. The position, the interlace enable, the field-polarity invert and the incoming odd/even field signal are all sampled at the start-of-field pulse.

In interlaced mode the block steps two rows per line. The row parity in each field follows from the position parity and the field. In progressive mode it steps one row per line. The block has no stream interface. Every pin is a plain control or status signal, so there is no back-pressure. Outputs change only on the clock edge that samples a line strobe, and they hold their values between strobes.

Top module: `icur_rowseq`

## Requirements
- R1: After reset, `row_vld` is 0 and stays 0 until a field has been started and a matching line arrives.
- R2: In interlaced mode, each line strobe while the cursor is visible advances `row_addr` by exactly 2.
- R3: With interlace on and a position from 65 to 4095 that is even, field value 0 shows row 0 first, on screen line position−64. Field value 1 shows row 1 first, on line position−63.
- R4: With interlace on and an odd position from 65 to 4095, field value 1 shows row 0 first, on line position−64, and field value 0 shows row 1 first, on line position−63.
- R5: With interlace on and a position of 64 or less, the first visible row is N = 64 − position. Row N goes on line 0 in field 0, and row N+1 goes on line 1 in field 1. A position of 0 shows nothing.
- R6: The field value used is `field_odd` XOR `fld_inv`, both sampled at the start-of-field pulse.
- R7: Once the next row would exceed 63, `row_vld` goes to 0 and stays 0 until the next start-of-field pulse.
- R8: Changes to `ypos`, `ilace_en`, `fld_inv` or `field_odd` after the start-of-field pulse have no effect on the current field.
- R9: With interlace off, rows 0 to 63 appear one per line. Row r appears on line position−64+r. Rows above line 0 are clipped.
- R10: `row_vld` and `row_addr` update one clock after a line strobe and hold their values while no strobe or start pulse is present. A start-of-field pulse clears `row_vld`.
- R11: On lines before the cursor's first line in the current field, `row_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-field pulse, one cycle; samples the controls |
| line_stb | input | 1 | Scan-line strobe, one cycle per line |
| line_num | input | YW | Screen line number of the strobed line |
| ypos | input | YW | Cursor vertical position (bottom line + 1, offset 64) |
| ilace_en | input | 1 | 1 selects interlaced row stepping |
| fld_inv | input | 1 | 1 inverts the incoming field signal |
| field_odd | input | 1 | Field indicator: 0 even field, 1 odd field |
| row_vld | output | 1 | Cursor covers the current line |
| row_addr | output | 6 | Pattern row for the current line |

## Verification
Checked on every cycle by the assertions:
- a visible row advances by the configured step on each strobe;
- outputs hold between strobes;
- a start pulse clears the flag;
- a finished field stays dark;
- lines ahead of the start line show nothing.

Only the bench's scenarios can show that the first row and first line are correct for each position parity, field polarity and clipped position, and that mid-field control changes are ignored. The bench checks these against a geometric model: the row is line − position + 64, and it is valid from 0 to 63.

// File: rtl/icur_pkg.sv
package icur_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_RUN  = 2'd2,
    SQ_DONE = 2'd3
  } seq_st_t;
endpackage

// File: rtl/icur_start_calc.sv
// Computes, from the live controls at a start-of-field pulse, the first row,
// the screen line carrying it, the per-line step and whether nothing shows.
module icur_start_calc #(
  parameter int YW   = 12,
  parameter int ROWS = 64,
  parameter int RW   = 8
) (
  input  logic [YW-1:0] ypos,
  input  logic          ilace_en,
  input  logic          fld_inv,
  input  logic          field_odd,
  output logic [RW-1:0] srow_o,
  output logic [YW-1:0] sline_o,
  output logic [1:0]    step_o,
  output logic          none_o
);
  localparam int CW = YW + 1;

  logic [CW-1:0] yx, rows_c, n_top, top_line, srow_w, sline_w;
  logic          fld, clip;

  assign yx       = {1'b0, ypos};
  assign rows_c   = CW'(ROWS);
  assign fld      = field_odd ^ fld_inv;
  assign clip     = (yx <= rows_c);
  assign n_top    = rows_c - yx;
  assign top_line = yx - rows_c;

  always_comb begin
    step_o = ilace_en ? 2'd2 : 2'd1;
    if (clip) begin
      srow_w  = n_top + (ilace_en ? CW'(fld) : '0);
      sline_w = ilace_en ? CW'(fld) : '0;
    end else begin
      srow_w  = ilace_en ? CW'(yx[0] ^ fld) : '0;
      sline_w = top_line + srow_w;
    end
  end

  assign srow_o  = srow_w[RW-1:0];
  assign sline_o = sline_w[YW-1:0];
  assign none_o  = (srow_w >= rows_c);
endmodule

// File: rtl/icur_row_seq.sv
// Row counter: loads at start of field, waits for the start line, then
// emits one row per line strobe until the pattern is exhausted.
module icur_row_seq
  import icur_pkg::*;
#(
  parameter int YW   = 12,
  parameter int ROWS = 64,
  parameter int AW   = 6,
  parameter int RW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof,
  input  logic          line_stb,
  input  logic [YW-1:0] line_num,
  input  logic [RW-1:0] srow_in,
  input  logic [YW-1:0] sline_in,
  input  logic [1:0]    step_in,
  input  logic          none_in,
  output logic          row_vld,
  output logic [AW-1:0] row_addr,
  output seq_st_t       st_o,
  output logic [YW-1:0] sline_o,
  output logic [1:0]    step_o
);
  seq_st_t       st_q;
  logic [RW-1:0] cnt_q;
  logic [YW-1:0] sline_q;
  logic [1:0]    step_q;
  logic          more;

  assign more = (cnt_q < RW'(ROWS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      cnt_q    <= '0;
      sline_q  <= '0;
      step_q   <= 2'd1;
      row_vld  <= 1'b0;
      row_addr <= '0;
    end else if (sof) begin
      row_vld <= 1'b0;
      cnt_q   <= srow_in;
      sline_q <= sline_in;
      step_q  <= step_in;
      st_q    <= none_in ? SQ_DONE : SQ_WAIT;
    end else if (line_stb) begin
      case (st_q)
        SQ_WAIT: begin
          if (line_num == sline_q) begin
            row_vld  <= 1'b1;
            row_addr <= cnt_q[AW-1:0];
            cnt_q    <= cnt_q + RW'(step_q);
            st_q     <= SQ_RUN;
          end else begin
            row_vld <= 1'b0;
          end
        end
        SQ_RUN: begin
          if (more) begin
            row_vld  <= 1'b1;
            row_addr <= cnt_q[AW-1:0];
            cnt_q    <= cnt_q + RW'(step_q);
          end else begin
            row_vld <= 1'b0;
            st_q    <= SQ_DONE;
          end
        end
        default: row_vld <= 1'b0;
      endcase
    end
  end

  assign st_o    = st_q;
  assign sline_o = sline_q;
  assign step_o  = step_q;
endmodule

// File: rtl/icur_rowseq.sv
module icur_rowseq
  import icur_pkg::*;
#(
  parameter int YW   = 12,
  parameter int ROWS = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sof,
  input  logic                    line_stb,
  input  logic [YW-1:0]           line_num,
  input  logic [YW-1:0]           ypos,
  input  logic                    ilace_en,
  input  logic                    fld_inv,
  input  logic                    field_odd,
  output logic                    row_vld,
  output logic [$clog2(ROWS)-1:0] row_addr
);
  localparam int AW = $clog2(ROWS);
  localparam int RW = AW + 2;

  logic [RW-1:0] srow;
  logic [YW-1:0] sline, seq_sline;
  logic [1:0]    step, seq_step;
  logic          none;
  seq_st_t       seq_st;

  icur_start_calc #(.YW(YW), .ROWS(ROWS), .RW(RW)) u_start (
    .ypos     (ypos),
    .ilace_en (ilace_en),
    .fld_inv  (fld_inv),
    .field_odd(field_odd),
    .srow_o   (srow),
    .sline_o  (sline),
    .step_o   (step),
    .none_o   (none)
  );

  icur_row_seq #(.YW(YW), .ROWS(ROWS), .AW(AW), .RW(RW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .sof     (sof),
    .line_stb(line_stb),
    .line_num(line_num),
    .srow_in (srow),
    .sline_in(sline),
    .step_in (step),
    .none_in (none),
    .row_vld (row_vld),
    .row_addr(row_addr),
    .st_o    (seq_st),
    .sline_o (seq_sline),
    .step_o  (seq_step)
  );
endmodule

// File: rtl/icur_rowseq_chk.sv
module icur_rowseq_chk
  import icur_pkg::*;
#(
  parameter int YW = 12,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sof,
  input logic          line_stb,
  input logic [YW-1:0] line_num,
  input logic          row_vld,
  input logic [AW-1:0] row_addr,
  input seq_st_t       st,
  input logic [YW-1:0] sline,
  input logic [1:0]    step
);
  // R2 / R9: visible rows advance by the field's step
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !sof && row_vld) |=>
      (!row_vld || row_addr == $past(row_addr) + AW'(step)));

  // R10: outputs hold without a strobe or start pulse
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_stb && !sof) |=> ($stable(row_vld) && $stable(row_addr)));

  // R10: start pulse clears the flag
  p_sof_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !row_vld);

  // R7: finished field stays dark
  p_done_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_DONE && !sof) |=> !row_vld);

  // R11: lines ahead of the start line show nothing
  p_pre_dark_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_WAIT && line_stb && !sof && line_num != sline) |=> !row_vld);
endmodule

bind icur_rowseq icur_rowseq_chk #(.YW(YW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sof     (sof),
  .line_stb(line_stb),
  .line_num(line_num),
  .row_vld (row_vld),
  .row_addr(row_addr),
  .st      (seq_st),
  .sline   (seq_sline),
  .step    (seq_step)
);

// File: tb/sim_icur_rowseq.sv
module sim_icur_rowseq;
  localparam int YW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sof = 1'b0, line_stb = 1'b0;
  logic [YW-1:0] line_num = '0, ypos = '0;
  logic          ilace_en = 1'b0, fld_inv = 1'b0, field_odd = 1'b0;
  logic          row_vld;
  logic [5:0]    row_addr;

  always #2 clk = ~clk;

  icur_rowseq u0 (
    .clk(clk), .rst_n(rst_n), .sof(sof), .line_stb(line_stb),
    .line_num(line_num), .ypos(ypos), .ilace_en(ilace_en),
    .fld_inv(fld_inv), .field_odd(field_odd),
    .row_vld(row_vld), .row_addr(row_addr)
  );

  typedef struct { bit v; int r; string tag; } exp_t;
  exp_t q[$];
  exp_t e;
  int   checks = 0, errors = 0;
  bit   stb_seen = 1'b0;
  bit   done = 1'b0;
  int   cyc = 0;

  // Scoreboard monitor
  always @(posedge clk) stb_seen <= line_stb;

  always @(negedge clk) begin
    if (stb_seen) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual vld=%0d row=%0d expected none", row_vld, row_addr);
      end else begin
        e = q.pop_front();
        if (row_vld !== e.v || (e.v && row_addr !== e.r[5:0])) begin
          errors++;
          $display("FAIL %s line=%0d: actual vld=%0d row=%0d expected vld=%0d row=%0d",
                   e.tag, line_num, row_vld, row_addr, e.v, e.r);
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Geometric reference: row = line - position + 64, valid 0..63
  task automatic push_exp(input int line, input int y, input string tag);
    exp_t x;
    int r = line + 64 - y;
    x.v = (r >= 0 && r <= 63);
    x.r = x.v ? r : 0;
    x.tag = tag;
    q.push_back(x);
  endtask

  task automatic start_field(input int y, input bit il, input bit inv, input bit fo);
    @(negedge clk);
    ypos = YW'(y); ilace_en = il; fld_inv = inv; field_odd = fo;
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
  endtask

  task automatic feed(input int y, input int base, input int stp, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      line_num = YW'(base + i * stp);
      push_exp(base + i * stp, y, tag);
      line_stb = 1'b1;
      @(negedge clk);
      line_stb = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic run_field(input int y, input bit il, input bit inv, input bit fo,
                           input int base, input int n, input string tag);
    start_field(y, il, inv, fo);
    feed(y, base, il ? 2 : 1, n, tag);
  endtask

  bit    hv;
  logic [5:0] ha;

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    checks++;
    if (row_vld !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual vld=%0d expected 0", row_vld);
    end
    rst_n = 1'b1;
    @(negedge clk);

    run_field(100, 1, 0, 0, 30, 60, "R3 even pos even field");   // also R2 R7 R11
    run_field(100, 1, 0, 1, 31, 60, "R3 even pos odd field");
    run_field(101, 1, 0, 1, 31, 60, "R4 odd pos odd field");
    run_field(101, 1, 0, 0, 30, 60, "R4 odd pos even field");
    run_field(4095, 1, 0, 1, 4001, 47, "R4 top position");
    run_field(65, 1, 0, 1, 1, 40, "R4 position 65");
    run_field(10, 1, 0, 0, 0, 12, "R5 clipped even field");
    run_field(10, 1, 0, 1, 1, 12, "R5 clipped odd field");
    run_field(64, 1, 0, 0, 0, 40, "R5 position 64");
    run_field(1, 1, 0, 1, 1, 4, "R5 position 1 odd");
    run_field(0, 1, 0, 0, 0, 6, "R5 position 0");
    run_field(100, 1, 1, 1, 30, 60, "R6 invert to even");
    run_field(101, 1, 1, 0, 31, 60, "R6 invert to odd");
    run_field(70, 0, 0, 0, 0, 80, "R9 progressive");
    run_field(20, 0, 0, 0, 0, 30, "R9 progressive clipped");

    // R8: controls changed after the start pulse are ignored
    start_field(100, 1, 0, 0);
    ypos = 12'd10; ilace_en = 1'b0; fld_inv = 1'b1; field_odd = 1'b1;
    feed(100, 30, 2, 60, "R8 mid-field change");

    // R10: outputs hold between strobes
    start_field(80, 0, 0, 0);
    feed(80, 0, 1, 20, "R10 setup");
    hv = row_vld; ha = row_addr;
    repeat (5) @(negedge clk);
    checks++;
    if (row_vld !== hv || row_addr !== ha) begin
      errors++;
      $display("FAIL R10 hold: actual vld=%0d row=%0d expected vld=%0d row=%0d",
               row_vld, row_addr, hv, ha);
    end
    // R10: start pulse clears the flag
    start_field(80, 0, 0, 0);
    checks++;
    if (row_vld !== 1'b0) begin
      errors++;
      $display("FAIL R10 sof clear: actual vld=%0d expected 0", row_vld);
    end

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover: actual %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule